// File: doc/BRIEF.md
# Overlapping-Window Packet Energy Detector

This block watches a stream of complex baseband samples and measures the received energy over overlapping windows. It uses this measurement to decide whether a packet preamble is present. Each window spans 256 accepted samples. A new window starts every 80 samples, which is one OFDM symbol including its guard interval. As a result, every sample contributes to up to four windows.

Instead of summing each window from scratch, the block accumulates the squared magnitude of the samples into segment sums. Each segment covers the greatest common divisor of the window and hop lengths, which is 16 samples. A ring of 16 segment sums keeps a running total: on each segment boundary the newest segment is added and the oldest is dropped. Every fifth segment boundary after the ring first fills, the total is reported together with its window index. The total is then compared with a threshold supplied on a port.

The first window whose energy reaches the threshold produces a detect pulse. After that, the block stops taking samples until it is re-armed or reset. Downstream synchronisation logic can then take over the captured position in the stream.

Top module: `hop_energy_detector`

## Requirements
- R1: Samples are accepted on a rising edge where `in_valid` and `in_ready` are both high. `in_sample[31:16]` carries I and `in_sample[15:0]` carries Q, each as 16-bit two's complement. While running, `in_ready` is high.
- R2: Each reported `eval_energy` equals the sum of I*I + Q*Q over 256 consecutive accepted samples.
- R3: The energy path is 40 bits wide. A window of 256 full-scale samples (I = Q = -32768) reports exactly 2^39.
- R4: The first window ends with the 256th sample accepted since a clear, and each later window ends 80 accepted samples after the previous one. `eval_valid` is a one-cycle pulse in the cycle after the edge that accepted the window's last sample.
- R5: `eval_index` is 0 for the first window after a clear and increases by one for each subsequent window.
- R6: `detect` pulses together with `eval_valid` when the window energy is greater than or equal to `thresh`, with `thresh` sampled on the edge that accepts the window's last sample. Equality counts as a detection.
- R7: After a detection, `in_ready` stays low. No further sample is accepted and no window is reported until `rearm` or `rst`.
- R8: A one-cycle `rearm` clears all segment sums, the counters, the window index and the halt state. The next window is built only from samples accepted after it.
- R9: `rst` is synchronous and active-high. It clears the same state as `rearm` and also drives `eval_valid`, `detect`, `eval_index` and `eval_energy` to zero.
- R10: Cycles with `in_valid` low change neither the sums nor the window schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rearm | input | 1 | Clears the detector state and resumes sample intake |
| in_valid | input | 1 | Sample present |
| in_ready | output | 1 | Block can take a sample (low after a detection) |
| in_sample | input | 32 | I in bits 31:16, Q in bits 15:0 |
| thresh | input | 40 | Detection threshold on window energy |
| eval_valid | output | 1 | One-cycle pulse: a window energy is reported |
| eval_energy | output | 40 | Energy of the last reported window |
| eval_index | output | 16 | Index of the last reported window |
| detect | output | 1 | One-cycle pulse: the reported window reached the threshold |

## Verification
Every window result appears exactly one cycle after the rising edge that accepts the window's last sample. The bench samples on the falling edge that follows. At that point it requires that the count of presented samples equals 256 plus 80 times the window number, and that the energy, index and detect flag match a model summed from the same sample formula. The halt takes effect on that same edge. From the next falling edge onward, the bench expects `in_ready` low and no further reports, and it checks that no extra samples were taken. Reset and re-arm results are checked one edge after the pulse.

// File: rtl/ed_pkg.sv
package ed_pkg;

    // Fixed sample format: two 16-bit two's complement halves.
    localparam int unsigned ED_SMP_W = 16;
    localparam int unsigned ED_SQ_W  = 2 * ED_SMP_W;

    typedef struct packed {
        logic signed [ED_SMP_W-1:0] re;
        logic signed [ED_SMP_W-1:0] im;
    } cplx_t;

    typedef enum logic {
        ST_RUN  = 1'b0,
        ST_HALT = 1'b1
    } det_state_t;

    function automatic int unsigned ed_gcd(input int unsigned a, input int unsigned b);
        int unsigned x;
        int unsigned y;
        int unsigned t;
        x = a;
        y = b;
        while (y != 0) begin
            t = x % y;
            x = y;
            y = t;
        end
        return x;
    endfunction

    function automatic int unsigned ed_bits(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ed_mag2.sv
module ed_mag2
    import ed_pkg::*;
(
    input  cplx_t              smp,
    output logic [ED_SQ_W-1:0] pwr
);
    logic signed [ED_SQ_W-1:0] re_x;
    logic signed [ED_SQ_W-1:0] im_x;
    logic signed [ED_SQ_W-1:0] re_sq;
    logic signed [ED_SQ_W-1:0] im_sq;

    always_comb begin
        re_x  = {{ED_SMP_W{smp.re[ED_SMP_W-1]}}, smp.re};
        im_x  = {{ED_SMP_W{smp.im[ED_SMP_W-1]}}, smp.im};
        re_sq = re_x * re_x;
        im_sq = im_x * im_x;
        // Each square is at most 2^30, so the sum fits in 32 unsigned bits.
        pwr   = $unsigned(re_sq) + $unsigned(im_sq);
    end
endmodule

// File: rtl/ed_seg_accum.sv
module ed_seg_accum #(
    parameter int unsigned SEG_LEN = 16,
    parameter int unsigned SQ_W    = 32,
    parameter int unsigned SEG_W   = 36
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [SQ_W-1:0]  pwr,
    output logic             seg_done,
    output logic [SEG_W-1:0] seg_sum
);
    localparam int unsigned CNT_W = ed_pkg::ed_bits(SEG_LEN);

    logic [SEG_W-1:0] acc;
    logic [CNT_W-1:0] cnt;
    logic             last;

    assign last     = (cnt == CNT_W'(SEG_LEN - 1));
    assign seg_done = take && last;
    assign seg_sum  = acc + SEG_W'(pwr);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc <= '0;
            cnt <= '0;
        end else if (take) begin
            if (last) begin
                acc <= '0;
                cnt <= '0;
            end else begin
                acc <= seg_sum;
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/ed_window_ring.sv
module ed_window_ring #(
    parameter int unsigned SEGS  = 16,
    parameter int unsigned SEG_W = 36,
    parameter int unsigned ACC_W = 40
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             push,
    input  logic [SEG_W-1:0] seg_sum,
    output logic [ACC_W-1:0] win_sum
);
    localparam int unsigned PTR_W = ed_pkg::ed_bits(SEGS);

    logic [SEG_W-1:0] slot_w [SEGS];
    logic [PTR_W-1:0] ptr;
    logic [ACC_W-1:0] total;
    logic [SEG_W-1:0] oldest;

    for (genvar g = 0; g < SEGS; g++) begin : g_slot
        logic [SEG_W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                q <= '0;
            else if (push && (ptr == PTR_W'(g)))
                q <= seg_sum;
        end
        assign slot_w[g] = q;
    end

    assign oldest  = slot_w[ptr];
    // The total always equals the sum of the slots, so the subtraction cannot wrap.
    assign win_sum = total + ACC_W'(seg_sum) - ACC_W'(oldest);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            ptr   <= '0;
            total <= '0;
        end else if (push) begin
            total <= win_sum;
            ptr   <= (ptr == PTR_W'(SEGS - 1)) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/ed_hop_ctrl.sv
module ed_hop_ctrl #(
    parameter int unsigned SEGS     = 16,
    parameter int unsigned HOP_SEGS = 5,
    parameter int unsigned IDX_W    = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             seg_done,
    output logic             win_end,
    output logic [IDX_W-1:0] win_idx
);
    localparam int unsigned FILL_W = ed_pkg::ed_bits(SEGS);
    localparam int unsigned HOPC_W = ed_pkg::ed_bits(HOP_SEGS);

    logic [FILL_W-1:0] fill_cnt;
    logic [HOPC_W-1:0] hop_cnt;
    logic              filled;

    assign win_end = seg_done &&
                     (filled ? (hop_cnt == HOPC_W'(HOP_SEGS - 1))
                             : (fill_cnt == FILL_W'(SEGS - 1)));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fill_cnt <= '0;
            hop_cnt  <= '0;
            filled   <= 1'b0;
            win_idx  <= '0;
        end else if (seg_done) begin
            if (!filled) begin
                fill_cnt <= fill_cnt + 1'b1;
                filled   <= win_end;
            end else begin
                hop_cnt  <= win_end ? '0 : hop_cnt + 1'b1;
            end
            if (win_end)
                win_idx <= win_idx + 1'b1;
        end
    end
endmodule

// File: rtl/hop_energy_detector.sv
module hop_energy_detector
    import ed_pkg::*;
#(
    parameter  int unsigned WIN_LEN = 256,
    parameter  int unsigned HOP_LEN = 80,
    parameter  int unsigned IDX_W   = 16,
    localparam int unsigned ACC_W   = ED_SQ_W + $clog2(WIN_LEN)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  rearm,
    input  logic                  in_valid,
    output logic                  in_ready,
    input  logic [2*ED_SMP_W-1:0] in_sample,
    input  logic [ACC_W-1:0]      thresh,
    output logic                  eval_valid,
    output logic [ACC_W-1:0]      eval_energy,
    output logic [IDX_W-1:0]      eval_index,
    output logic                  detect
);
    localparam int unsigned SEG_LEN  = ed_gcd(WIN_LEN, HOP_LEN);
    localparam int unsigned SEGS     = WIN_LEN / SEG_LEN;
    localparam int unsigned HOP_SEGS = HOP_LEN / SEG_LEN;
    localparam int unsigned SEG_W    = ED_SQ_W + ed_bits(SEG_LEN);

    det_state_t         state;
    cplx_t              smp;
    logic               take;
    logic [ED_SQ_W-1:0] pwr;
    logic               seg_done;
    logic [SEG_W-1:0]   seg_sum;
    logic [ACC_W-1:0]   win_sum;
    logic               win_end;
    logic [IDX_W-1:0]   win_idx;
    logic               hit;

    assign smp      = cplx_t'(in_sample);
    assign in_ready = (state == ST_RUN);
    assign take     = in_valid && in_ready && !rearm;
    assign hit      = (win_sum >= thresh);

    ed_mag2 u_mag2 (
        .smp (smp),
        .pwr (pwr)
    );

    ed_seg_accum #(
        .SEG_LEN (SEG_LEN),
        .SQ_W    (ED_SQ_W),
        .SEG_W   (SEG_W)
    ) u_seg (
        .clk      (clk),
        .rst      (rst),
        .clr      (rearm),
        .take     (take),
        .pwr      (pwr),
        .seg_done (seg_done),
        .seg_sum  (seg_sum)
    );

    ed_window_ring #(
        .SEGS  (SEGS),
        .SEG_W (SEG_W),
        .ACC_W (ACC_W)
    ) u_ring (
        .clk     (clk),
        .rst     (rst),
        .clr     (rearm),
        .push    (seg_done),
        .seg_sum (seg_sum),
        .win_sum (win_sum)
    );

    ed_hop_ctrl #(
        .SEGS     (SEGS),
        .HOP_SEGS (HOP_SEGS),
        .IDX_W    (IDX_W)
    ) u_hop (
        .clk      (clk),
        .rst      (rst),
        .clr      (rearm),
        .seg_done (seg_done),
        .win_end  (win_end),
        .win_idx  (win_idx)
    );

    always_ff @(posedge clk) begin
        if (rst || rearm) begin
            state       <= ST_RUN;
            eval_valid  <= 1'b0;
            detect      <= 1'b0;
            eval_energy <= '0;
            eval_index  <= '0;
        end else begin
            eval_valid <= win_end;
            detect     <= win_end && hit;
            if (win_end) begin
                eval_energy <= win_sum;
                eval_index  <= win_idx;
                if (hit)
                    state <= ST_HALT;
            end
        end
    end
endmodule

// File: rtl/ed_checker.sv
module ed_checker #(
    parameter int unsigned ACC_W   = 40,
    parameter int unsigned IDX_W   = 16,
    parameter int unsigned WIN_LEN = 256
) (
    input logic             clk,
    input logic             rst,
    input logic             rearm,
    input logic             in_valid,
    input logic             in_ready,
    input logic [ACC_W-1:0] thresh,
    input logic             eval_valid,
    input logic [ACC_W-1:0] eval_energy,
    input logic [IDX_W-1:0] eval_index,
    input logic             detect
);
    localparam logic [ACC_W-1:0] MAX_E = ACC_W'(WIN_LEN) << (2 * ed_pkg::ED_SMP_W - 1);

    // R6: a detection always comes with a reported window
    p_detect_with_eval_r6: assert property (@(posedge clk) disable iff (rst)
        detect |-> eval_valid);

    // R6: reported energy versus the threshold sampled at the deciding edge
    p_detect_reached_r6: assert property (@(posedge clk) disable iff (rst)
        detect |-> (eval_energy >= $past(thresh)));
    p_miss_below_r6: assert property (@(posedge clk) disable iff (rst)
        (eval_valid && !detect) |-> (eval_energy < $past(thresh)));

    // R7: intake stops after a detection unless re-armed
    p_halt_after_detect_r7: assert property (@(posedge clk) disable iff (rst)
        (detect && !rearm) |=> !in_ready);
    p_quiet_while_halted_r7: assert property (@(posedge clk) disable iff (rst)
        (!in_ready && !detect) |-> !eval_valid);

    // R10: a report needs a sample taken on the previous edge
    p_eval_needs_sample_r10: assert property (@(posedge clk) disable iff (rst)
        eval_valid |-> $past(in_valid && in_ready));

    // R3: energy never exceeds a full-scale window
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        eval_valid |-> (eval_energy <= MAX_E));

    // R9: reset state one edge after reset
    p_reset_state_r9: assert property (@(posedge clk)
        rst |=> (in_ready && !eval_valid && !detect && eval_index == '0 && eval_energy == '0));
endmodule

bind hop_energy_detector ed_checker #(
    .ACC_W   (ACC_W),
    .IDX_W   (IDX_W),
    .WIN_LEN (WIN_LEN)
) u_ed_checker (
    .clk         (clk),
    .rst         (rst),
    .rearm       (rearm),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .thresh      (thresh),
    .eval_valid  (eval_valid),
    .eval_energy (eval_energy),
    .eval_index  (eval_index),
    .detect      (detect)
);

// File: tb/test_hop_energy_detector.sv
module test_hop_energy_detector;
    localparam int WIN   = 256;
    localparam int HOP   = 80;
    localparam int NWIN  = 6;
    localparam int NFEED = WIN + HOP * (NWIN - 1);
    localparam int ACC_W = 40;
    localparam int IDX_W = 16;
    localparam int NVEC  = 7;

    // i0, di, q0, dq, thr_window(-1 none), thr_add, junk, gaps, use_reset
    localparam int TBL [NVEC][9] = '{
        '{ 100,   3,   40,   1, -1, 0,   0, 0, 0},
        '{ 100,   3,   40,   1,  2, 0,   0, 1, 0},
        '{ 100,   3,   40,   1,  2, 1,  37, 0, 0},
        '{  -7, -11,    5,   9,  0, 0,   0, 0, 0},
        '{1000,  -1,    0,   0,  4, 0,   0, 1, 0},
        '{-32768, 0, -32768, 0, -1, 0,   0, 0, 0},
        '{ 300,   7, -200,  -5, -1, 0, 200, 0, 1}
    };

    logic             clk = 1'b0;
    logic             rst;
    logic             rearm;
    logic             in_valid;
    logic             in_ready;
    logic [31:0]      in_sample;
    logic [ACC_W-1:0] thresh;
    logic             eval_valid;
    logic [ACC_W-1:0] eval_energy;
    logic [IDX_W-1:0] eval_index;
    logic             detect;

    always #10 clk = ~clk;

    hop_energy_detector i_hop_energy_detector (
        .clk         (clk),
        .rst         (rst),
        .rearm       (rearm),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_sample   (in_sample),
        .thresh      (thresh),
        .eval_valid  (eval_valid),
        .eval_energy (eval_energy),
        .eval_index  (eval_index),
        .detect      (detect)
    );

    int     total_cnt = 0;
    int     bad_cnt   = 0;
    longint exp_e [NWIN];
    int     exp_det;
    int     ev_cnt;
    int     n_fed;
    bit     watch;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        total_cnt++;
        if (!ok) begin
            bad_cnt++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic longint smp_pow(input int i0, input int di, input int q0, input int dq, input int n);
        logic signed [15:0] a;
        logic signed [15:0] b;
        a = 16'(i0 + di * n);
        b = 16'(q0 + dq * n);
        return longint'(a) * longint'(a) + longint'(b) * longint'(b);
    endfunction

    function automatic logic [31:0] smp_word(input int i0, input int di, input int q0, input int dq, input int n);
        return {16'(i0 + di * n), 16'(q0 + dq * n)};
    endfunction

    // One falling edge: check any window report, then the caller drives inputs.
    task automatic step();
        @(negedge clk);
        if (eval_valid) begin
            if (!watch) begin
                check(1'b0, "R8 report from discarded samples", 1, 0);
            end else begin
                check(n_fed == WIN + HOP * ev_cnt, "R4 report timing", n_fed, WIN + HOP * ev_cnt);
                check(eval_index == IDX_W'(ev_cnt), "R5 window index", eval_index, ev_cnt);
                if (ev_cnt < NWIN)
                    check(eval_energy == ACC_W'(exp_e[ev_cnt]), "R2 window energy", eval_energy, exp_e[ev_cnt]);
                check(detect == (ev_cnt == exp_det), "R6 detect flag", detect, ev_cnt == exp_det);
                ev_cnt++;
            end
        end else if (detect) begin
            check(1'b0, "R6 detect without report", 1, 0);
        end
    endtask

    task automatic run_vec(input int v);
        int     i0, di, q0, dq, tsel, tadd, junk, gaps, use_rst;
        longint thr;
        int     halt_cyc;
        int     cyc;
        int     exp_cnt;
        i0 = TBL[v][0]; di = TBL[v][1]; q0 = TBL[v][2]; dq = TBL[v][3];
        tsel = TBL[v][4]; tadd = TBL[v][5]; junk = TBL[v][6]; gaps = TBL[v][7]; use_rst = TBL[v][8];

        for (int k = 0; k < NWIN; k++) begin
            exp_e[k] = 0;
            for (int j = 0; j < WIN; j++)
                exp_e[k] += smp_pow(i0, di, q0, dq, HOP * k + j);
        end
        thr = (tsel < 0) ? ((longint'(1) << ACC_W) - 1) : exp_e[tsel] + tadd;
        exp_det = -1;
        for (int k = 0; k < NWIN; k++)
            if (exp_det < 0 && exp_e[k] >= thr) exp_det = k;
        thresh = ACC_W'(thr);

        watch = 1'b0;
        step(); rearm = 1'b1; in_valid = 1'b0;
        step(); rearm = 1'b0;
        for (int i = 0; i < junk; i++) begin
            step(); in_valid = 1'b1; in_sample = {16'sd20000, -16'sd20000};
        end
        step(); in_valid = 1'b0;

        if (use_rst != 0) begin
            rst = 1'b1;
            step(); rst = 1'b0;
            // R9: reset state visible one edge later
            check(in_ready && !eval_valid && !detect, "R9 reset flags", {in_ready, eval_valid, detect}, 3'b100);
            check(eval_index == '0, "R9 reset index", eval_index, 0);
            check(eval_energy == '0, "R9 reset energy", eval_energy, 0);
        end else begin
            rearm = 1'b1;
            step(); rearm = 1'b0;
            check(in_ready == 1'b1, "R8 ready after rearm", in_ready, 1);
        end

        watch = 1'b1; ev_cnt = 0; n_fed = 0; halt_cyc = 0; cyc = 0;
        while (n_fed < NFEED && halt_cyc < 12) begin
            step();
            cyc++;
            if (!in_ready) begin
                halt_cyc++;
                check(exp_det >= 0 && ev_cnt == exp_det + 1, "R7 ready low only after detect", ev_cnt, exp_det + 1);
                in_valid  = 1'b1;
                in_sample = smp_word(i0, di, q0, dq, n_fed);
            end else if (gaps != 0 && (cyc % 4) == 1) begin
                in_valid = 1'b0;
            end else begin
                in_valid  = 1'b1;
                in_sample = smp_word(i0, di, q0, dq, n_fed);
                n_fed++;
            end
        end
        step(); in_valid = 1'b0;
        repeat (3) step();

        exp_cnt = (exp_det >= 0) ? exp_det + 1 : NWIN;
        check(ev_cnt == exp_cnt, "R4 number of windows", ev_cnt, exp_cnt);
        if (exp_det >= 0) begin
            check(n_fed == WIN + HOP * exp_det, "R7 samples taken before halt", n_fed, WIN + HOP * exp_det);
            check(in_ready == 1'b0, "R7 still halted", in_ready, 0);
        end
        if (gaps != 0)
            check(ev_cnt == exp_cnt, "R10 idle cycles keep schedule", ev_cnt, exp_cnt);
        if (v == 5)
            check(eval_energy == ACC_W'(longint'(1) << 39), "R3 full-scale window", eval_energy, longint'(1) << 39);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total_cnt++;
        bad_cnt++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
    end

    initial begin
        rst = 1'b1; rearm = 1'b0; in_valid = 1'b0; in_sample = '0; thresh = '0;
        watch = 1'b0; ev_cnt = 0; n_fed = 0; exp_det = -1;
        repeat (3) @(negedge clk);
        check(!eval_valid && !detect, "R9 outputs after reset", {eval_valid, detect}, 0);
        check(eval_index == '0 && eval_energy == '0, "R9 index and energy after reset", eval_energy, 0);
        rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        for (int v = 0; v < NVEC; v++)
            run_vec(v);
        $display("  test done: total=%0d bad=%0d", total_cnt, bad_cnt);
        $finish;
    end
endmodule